// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits on the system-clock side of a chip and drives an external asynchronous static RAM that is 16 bits wide with 16 address bits. A client offers one request at a time on a valid/ready handshake. Each request carries a direction flag, an address, write data and a two-bit byte-enable. The controller replays the request on the memory pins as a fixed sequence of clock-counted phases. It drives the active-low chip select, output enable, write strobe and the two byte-lane strobes, and it enables the chip's own data-bus driver only while a write is in progress. Reads return their data with a one-cycle response pulse.

The controller opens a write only when chip select, write strobe and at least one lane strobe are low together, and it closes the write by raising the write strobe and lane strobes together. Output enable stays high for the whole write, so the shorter write-pulse minimum applies. Each phase length is a parameter counted in clock cycles. The integrator rounds every nanosecond minimum up to whole cycles. The states are `ST_IDLE`, `ST_WSETUP`, `ST_WPULSE`, `ST_WHOLD`, `ST_RTURN` and `ST_RACCESS`. The transitions are as follows:
- idle to write-setup on an accepted write, or to read-turn on an accepted read;
- write-setup to write-pulse when its count ends;
- write-pulse to write-hold when its count ends;
- write-hold to idle after one cycle;
- read-turn to read-access when its count ends;
- read-access to idle when its count ends.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever no transaction is in flight, `req_ready` is 1, every memory control output is 1, `rsp_valid` is 0 and `sram_dq_oe` is 0. `req_ready` is 0 from the cycle after a request is accepted until the controller is idle again. Any request seen at a clock edge while `req_ready` is 1 is accepted.
- R2: A write begins with SETUP_CYC cycles in which chip select is 0, write strobe, output enable and both lane strobes are 1, and the data bus is driven.
- R3: Next come exactly WPULSE_CYC cycles with the write strobe at 0. The upper strobe (lane of bits 15:8) is 0 exactly when byte-enable bit 1 is set, and the lower strobe (bits 7:0) is 0 exactly when bit 0 is set. Output enable stays 1 whenever the write strobe is 0.
- R4: The write ends with one hold cycle in which write strobe and lane strobes are back at 1, chip select is still 0 and the bus is still driven. In the next cycle chip select returns to 1 and the bus is released.
- R5: From the cycle after acceptance to the end of the transaction, the address pins hold the request address. During a write, the data-out pins hold the write data.
- R6: A read holds chip select at 0 and the lane strobes at the inverse of the byte-enable. It first spends TURN_CYC cycles with output enable at 1, then ACCESS_CYC cycles with output enable at 0.
- R7: The bus driver is never enabled while output enable is 0. The driver is off in the cycle before output enable falls.
- R8: Read data is sampled on the last access cycle. `rsp_valid` is 1 for exactly the following cycle, with `rsp_rdata` holding the sampled lanes and zero in every lane whose byte-enable bit was clear.
- R9: `req_valid` and the request fields have no effect while `req_ready` is 0.
- R10: A write whose byte-enable is 00 leaves both lane strobes at 1 and so changes no memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper lane, bit 0 lower lane |
| req_ready | output | 1 | Controller idle and accepting |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 16 | Memory address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_ub_n | output | 1 | Upper-lane strobe, active low |
| sram_lb_n | output | 1 | Lower-lane strobe, active low |
| sram_dq_out | output | 16 | Data toward the memory |
| sram_dq_oe | output | 1 | Enable for the chip's data-bus driver |
| sram_dq_in | input | 16 | Data from the memory |

## Verification
Every pin is decoded from the state register, so a corrupt state shows up in the same cycle as a wrong strobe pattern, a bus driver fighting an enabled memory output, or `req_ready` out of step with the transaction. A phase counter that loads or expires early or late moves the write-strobe or output-enable edges by whole cycles. That error appears within one transaction, either as a wrong pin level in a specific cycle or as a read sampled before the access window closes. A lane-masking fault in the capture path shows only on the response cycle of a partial-lane read.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RTURN,
        ST_RACCESS
    } ctrl_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic lanes_on;
        logic drive;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                       lanes_on: 1'b0, drive: 1'b0};

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/lane_datapath.sv
module lane_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [LANES-1:0]  acc_be,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  be_q,
    output logic [DATA_W-1:0] rdata_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= acc_addr;
            wdata_q <= acc_wdata;
            be_q    <= acc_be;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata_q[g*8 +: 8] <= '0;
            end else if (capture) begin
                rdata_q[g*8 +: 8] <= be_q[g] ? dq_in[g*8 +: 8] : 8'h00;
            end
        end
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int WPULSE_CYC = 2,
    parameter int TURN_CYC   = 1,
    parameter int ACCESS_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [1:0]  req_be,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic [15:0] sram_addr,
    output logic        sram_ce_n,
    output logic        sram_oe_n,
    output logic        sram_we_n,
    output logic        sram_ub_n,
    output logic        sram_lb_n,
    output logic [15:0] sram_dq_out,
    output logic        sram_dq_oe,
    input  logic [15:0] sram_dq_in
);

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;
    localparam int MAX_A  = (SETUP_CYC > WPULSE_CYC) ? SETUP_CYC : WPULSE_CYC;
    localparam int MAX_B  = (TURN_CYC > ACCESS_CYC) ? TURN_CYC : ACCESS_CYC;
    localparam int MAX_PH = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_PH + 1) + 1;

    ctrl_state_e state_q, state_d;
    pin_ctl_t    pins;
    logic        phase_last;
    logic        tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic        accept;
    logic        capture;
    logic        rsp_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic [LANES-1:0]  lane_n;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign capture = (state_q == ST_RACCESS) && phase_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = req_write ? ST_WSETUP : ST_RTURN;
            ST_WSETUP:  if (phase_last) state_d = ST_WPULSE;
            ST_WPULSE:  if (phase_last) state_d = ST_WHOLD;
            ST_WHOLD:   state_d = ST_IDLE;
            ST_RTURN:   if (phase_last) state_d = ST_RACCESS;
            ST_RACCESS: if (phase_last) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // phase length loaded on entry to each timed state
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_WSETUP:  tmr_val = CNT_W'(SETUP_CYC - 1);
            ST_WPULSE:  tmr_val = CNT_W'(WPULSE_CYC - 1);
            ST_RTURN:   tmr_val = CNT_W'(TURN_CYC - 1);
            ST_RACCESS: tmr_val = CNT_W'(ACCESS_CYC - 1);
            default:    tmr_val = '0;
        endcase
    end

    phase_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .last    (phase_last)
    );

    lane_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .acc_addr (req_addr),
        .acc_wdata(req_wdata),
        .acc_be   (req_be),
        .capture  (capture),
        .dq_in    (sram_dq_in),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .be_q     (be_q),
        .rdata_q  (rsp_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= 1'b0;
        end else begin
            rsp_q <= capture;
        end
    end

    // pin decode per state
    always_comb begin
        pins = PINS_IDLE;
        unique case (state_q)
            ST_IDLE:    pins = PINS_IDLE;
            ST_WSETUP:  pins = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, lanes_on: 1'b0, drive: 1'b1};
            ST_WPULSE:  pins = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, lanes_on: 1'b1, drive: 1'b1};
            ST_WHOLD:   pins = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, lanes_on: 1'b0, drive: 1'b1};
            ST_RTURN:   pins = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, lanes_on: 1'b1, drive: 1'b0};
            ST_RACCESS: pins = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, lanes_on: 1'b1, drive: 1'b0};
            default:    pins = PINS_IDLE;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_strobe
        assign lane_n[g] = ~(pins.lanes_on & be_q[g]);
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign rsp_valid   = rsp_q;
    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;
    assign sram_ce_n   = pins.ce_n;
    assign sram_oe_n   = pins.oe_n;
    assign sram_we_n   = pins.we_n;
    assign sram_dq_oe  = pins.drive;
    assign sram_ub_n   = lane_n[LANES-1];
    assign sram_lb_n   = lane_n[0];

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [15:0] sram_addr,
    input logic        sram_ce_n,
    input logic        sram_oe_n,
    input logic        sram_we_n,
    input logic        sram_dq_oe
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && !sram_dq_oe));

    p_we_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_ce_n);

    p_oe_high_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);

    p_hold_after_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_dq_oe && !sram_ce_n));

    p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_oe_n) |-> !$past(sram_dq_oe));

    p_rsp_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .sram_addr (sram_addr),
    .sram_ce_n (sram_ce_n),
    .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n),
    .sram_dq_oe(sram_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;

    localparam int S = 2;
    localparam int P = 2;
    localparam int T = 1;
    localparam int A = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata, sram_addr, sram_dq_out, sram_dq_in;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe;

    always #2.5 clk = ~clk;

    sram_lane_ctrl #(.SETUP_CYC(S), .WPULSE_CYC(P), .TURN_CYC(T), .ACCESS_CYC(A)) i_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] fresh(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    // behavioural memory device on the pins
    logic [15:0] dev_mem [int];
    logic [15:0] gold    [int];

    function automatic logic [15:0] dev_rd(input logic [15:0] a);
        return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : fresh(a);
    endfunction

    always @* begin
        logic [15:0] w;
        w = dev_rd(sram_addr);
        sram_dq_in[15:8] = (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_ub_n) ? w[15:8] : 8'hEE;
        sram_dq_in[7:0]  = (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_lb_n) ? w[7:0]  : 8'hEE;
    end

    always @(negedge clk) begin
        if (!sram_ce_n && !sram_we_n) begin
            logic [15:0] w;
            w = dev_rd(sram_addr);
            if (!sram_ub_n) w[15:8] = sram_dq_oe ? sram_dq_out[15:8] : 8'h99;
            if (!sram_lb_n) w[7:0]  = sram_dq_oe ? sram_dq_out[7:0]  : 8'h99;
            dev_mem[int'(sram_addr)] = w;
        end
    end

    // request list
    bit          q_wr[$];
    logic [15:0] q_addr[$], q_data[$];
    logic [1:0]  q_be[$];
    string       q_tag[$];

    task automatic push(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be, input string tag);
        q_wr.push_back(wr); q_addr.push_back(a); q_data.push_back(d); q_be.push_back(be); q_tag.push_back(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit          m_busy = 0, m_wr = 0, m_rsp = 0;
        int          m_k = 0, m_end = 0, idle_run = 0;
        logic [15:0] m_addr = 0, m_data = 0, m_exp_rd = 0;
        logic [1:0]  m_be = 0;
        string       m_tag = "R8";
        bit          pv = 0, pw = 0;
        logic [15:0] pa = 0, pd = 0;
        logic [1:0]  pb = 0;
        string       pt = "R8";
        logic [15:0] junk = 16'h1357;

        push(1, 16'h0010, 16'hA1B2, 2'b11, "R3");
        push(0, 16'h0010, 16'h0000, 2'b11, "R8");
        push(1, 16'h0010, 16'hC3D4, 2'b10, "R3");
        push(0, 16'h0010, 16'h0000, 2'b11, "R3");
        push(1, 16'h0010, 16'hE5F6, 2'b01, "R3");
        push(0, 16'h0010, 16'h0000, 2'b11, "R3");
        push(1, 16'h0020, 16'h7777, 2'b00, "R10");
        push(0, 16'h0020, 16'h0000, 2'b11, "R10");
        push(0, 16'h0010, 16'h0000, 2'b10, "R8");
        push(0, 16'h0010, 16'h0000, 2'b01, "R8");
        push(1, 16'hFFFF, 16'h1234, 2'b11, "R5");
        push(1, 16'h0000, 16'hFEDC, 2'b11, "R5");
        push(0, 16'hFFFF, 16'h0000, 2'b11, "R5");
        push(0, 16'h0000, 16'h0000, 2'b11, "R5");
        push(0, 16'h4321, 16'h0000, 2'b11, "R8");

        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", req_ready, 1);
        chk("R1", "ce_n in reset", sram_ce_n, 1);
        rst_n = 1'b1;

        while (!done) begin
            @(negedge clk);
            // model step for the edge just passed
            m_rsp = 0;
            if (pv && !m_busy) begin
                m_busy = 1; m_k = 1; m_wr = pw; m_addr = pa; m_data = pd; m_be = pb; m_tag = pt;
                m_end = pw ? S + P + 2 : T + A + 1;
                if (pw) begin
                    logic [15:0] g;
                    g = gold.exists(int'(pa)) ? gold[int'(pa)] : fresh(pa);
                    if (pb[1]) g[15:8] = pd[15:8];
                    if (pb[0]) g[7:0]  = pd[7:0];
                    gold[int'(pa)] = g;
                end else begin
                    m_exp_rd = gold.exists(int'(pa)) ? gold[int'(pa)] : fresh(pa);
                    if (!pb[1]) m_exp_rd[15:8] = 8'h00;
                    if (!pb[0]) m_exp_rd[7:0]  = 8'h00;
                end
            end else if (m_busy) begin
                m_k++;
                if (m_k == m_end) begin
                    m_busy = 0;
                    m_rsp = !m_wr;
                end
            end

            // compare every output
            chk(m_busy ? "R9" : "R1", "req_ready", req_ready, !m_busy);
            chk("R8", "rsp_valid", rsp_valid, m_rsp);
            if (m_rsp) chk(m_tag, "rsp_rdata", rsp_rdata, m_exp_rd);
            if (!m_busy) begin
                chk("R1", "ce/oe/we/ub/lb/dqoe idle",
                    {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe}, 6'b111110);
            end else begin
                chk("R5", "sram_addr", sram_addr, m_addr);
                if (m_wr) begin
                    chk("R5", "sram_dq_out", sram_dq_out, m_data);
                    if (m_k <= S)
                        chk("R2", "write setup pins",
                            {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe}, 6'b011111);
                    else if (m_k <= S + P)
                        chk(m_be == 2'b00 ? "R10" : "R3", "write pulse pins",
                            {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe},
                            {3'b010, ~m_be[1], ~m_be[0], 1'b1});
                    else
                        chk("R4", "write hold pins",
                            {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe}, 6'b011111);
                end else begin
                    chk("R6", "read pins",
                        {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n},
                        {1'b0, (m_k <= T), 1'b1, ~m_be[1], ~m_be[0]});
                    chk("R7", "bus driver during read", sram_dq_oe, 0);
                end
            end

            // drive inputs for the next edge
            if (!m_busy) begin
                if (q_wr.size() != 0) begin
                    pv = 1; pw = q_wr.pop_front(); pa = q_addr.pop_front();
                    pd = q_data.pop_front(); pb = q_be.pop_front(); pt = q_tag.pop_front();
                    idle_run = 0;
                end else begin
                    pv = 0;
                    idle_run++;
                    if (idle_run > 4) done = 1;
                end
            end else begin
                junk = {junk[14:0], junk[15] ^ junk[13] ^ junk[12] ^ junk[10]};
                pv = 1; pw = junk[0]; pa = junk; pd = ~junk; pb = junk[3:2];
            end
            req_valid = pv; req_write = pw; req_addr = pa; req_wdata = pd; req_be = pb;
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule